// File: doc/BRIEF.md
# Object attribute table access port

This block sits between a host byte bus and an 8 KB cartridge RAM. Most of the RAM window passes straight through. A small cluster of registers near the top of the window provides indexed access to a table of sprite records held in that RAM. One register picks which of two table bases is in use. Another register picks an object number. Four byte ports then open onto that object's 4-byte record, and a fifth port reaches the object's 2-bit entry in a packed attribute area.

A write to the packed port is a read-modify-write of one RAM byte. It takes two RAM cycles, and the host is held off with a ready signal until the write-back is done. After reset, the block fetches its base, index and shift settings from the RAM bytes that mirror its registers, so the settings survive a reset of the block. Read data comes back one cycle after the request is accepted, flagged by a valid strobe.

Top module: `oat_port`

## Requirements
- R1: After reset is released, the block reads RAM offset 0x1FF5, then 0x1FF6, on consecutive cycles. It loads its base, index and shift from those two bytes using the same decoding as host writes. `host_ready` stays low until the third cycle after release.
- R2: A host access to any offset outside 0x1FF0–0x1FF6 reads or writes the RAM at exactly that offset.
- R3: A host write to 0x1FF5 stores the byte in RAM at 0x1FF5. Data bit 0 selects the table base: 1 selects 0x1800 and 0 selects 0x1C00.
- R4: A host write to 0x1FF6 stores the byte in RAM at 0x1FF6. It sets the object index to data[6:0] and the field shift to data[1:0] times two.
- R5: Host offsets 0x1FF0 to 0x1FF3 read or write RAM at base + 4×index + (offset − 0x1FF0).
- R6: A host read of 0x1FF4 returns the RAM byte at base + 0x200 + index/4, with the division truncated.
- R7: A host write to 0x1FF4 reads that same byte, replaces only bits [shift+1:shift] with data[1:0], and writes it back in the following cycle. `host_ready` is low during that write-back cycle.
- R8: Host reads of 0x1FF5 and 0x1FF6 return the RAM contents at those offsets.
- R9: `host_rvalid` is high, with `host_rdata` holding the requested byte, exactly one cycle after an accepted read, and low after an accepted write.
- R10: While the block is ready and no request is present, it drives no RAM access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host request, held until accepted |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 13 | Window offset |
| host_wdata | input | 8 | Write data |
| host_ready | output | 1 | Request is accepted in a cycle where this is high |
| host_rdata | output | 8 | Read data |
| host_rvalid | output | 1 | Read data valid, one cycle after acceptance |
| ram_en | output | 1 | RAM access strobe |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 13 | RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, one cycle after the strobe |

## Verification
A wrong base or index has no effect until the next access to ports 0x1FF0–0x1FF4. At that access it shows up on `ram_addr` in the same cycle, and on `host_rdata` one cycle later as the wrong record byte. A bad field shift or a bad merge shows up only in the byte that the write-back stores. It becomes visible the next time 0x1FF4 is read. A stuck state machine shows up right away as `host_ready` staying low or `ram_en` toggling with no request.

// File: rtl/oat_pkg.sv
package oat_pkg;
  localparam int WIN_W   = 13;
  localparam int DW      = 8;
  localparam int IDX_W   = 7;
  localparam int FLD_W   = 2;
  localparam int REC_LOG = 2;
  localparam int SHIFT_W = $clog2(DW);

  localparam logic [WIN_W-1:0] OFS_REC0 = 13'h1FF0;
  localparam logic [WIN_W-1:0] OFS_FLD  = 13'h1FF4;
  localparam logic [WIN_W-1:0] OFS_BASE = 13'h1FF5;
  localparam logic [WIN_W-1:0] OFS_IDX  = 13'h1FF6;
  localparam logic [WIN_W-1:0] TBL_HI   = 13'h1800;
  localparam logic [WIN_W-1:0] TBL_LO   = 13'h1C00;
  localparam logic [WIN_W-1:0] FLD_AREA = 13'h0200;

  typedef enum logic [2:0] {K_PLAIN, K_REC, K_FLD, K_BASE, K_IDX} kind_t;
  typedef enum logic [2:0] {S_LOAD_SEL, S_LOAD_IDX, S_LOAD_DONE, S_IDLE, S_WBACK} st_t;

  function automatic logic [WIN_W-1:0] table_base(input logic sel);
    return sel ? TBL_HI : TBL_LO;
  endfunction

  function automatic logic [WIN_W-1:0] rec_addr(input logic [WIN_W-1:0] base,
                                                input logic [IDX_W-1:0] idx,
                                                input logic [REC_LOG-1:0] k);
    logic [WIN_W-1:0] step;
    step = WIN_W'(idx) << REC_LOG;
    return base + step + WIN_W'(k);
  endfunction

  function automatic logic [WIN_W-1:0] field_addr(input logic [WIN_W-1:0] base,
                                                  input logic [IDX_W-1:0] idx);
    return base + FLD_AREA + WIN_W'(idx >> 2);
  endfunction

  function automatic logic [SHIFT_W-1:0] shift_of(input logic [1:0] lo);
    return {lo, 1'b0};
  endfunction

  function automatic logic [DW-1:0] merge_field(input logic [DW-1:0] old,
                                                input logic [FLD_W-1:0] val,
                                                input logic [SHIFT_W-1:0] sh);
    logic [DW-1:0] m;
    m = DW'({FLD_W{1'b1}}) << sh;
    return (old & ~m) | ((DW'(val) << sh) & m);
  endfunction
endpackage

// File: rtl/oat_regs.sv
module oat_regs
  import oat_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_sel,
  input  logic               ld_idx,
  input  logic               d_sel,
  input  logic [IDX_W-1:0]   d_idx,
  output logic               tbl_sel,
  output logic [IDX_W-1:0]   obj_idx,
  output logic [SHIFT_W-1:0] fld_shift
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbl_sel   <= 1'b0;
      obj_idx   <= '0;
      fld_shift <= '0;
    end else begin
      if (ld_sel) tbl_sel <= d_sel;
      if (ld_idx) begin
        obj_idx   <= d_idx;
        fld_shift <= shift_of(d_idx[1:0]);
      end
    end
  end
endmodule

// File: rtl/oat_decode.sv
module oat_decode
  import oat_pkg::*;
(
  input  logic [WIN_W-1:0] off,
  input  logic             tbl_sel,
  input  logic [IDX_W-1:0] obj_idx,
  output kind_t            kind,
  output logic [WIN_W-1:0] tgt
);
  logic [WIN_W-1:0] base;
  localparam logic [WIN_W-1:0] OFS_REC_LAST = OFS_REC0 + WIN_W'((1 << REC_LOG) - 1);

  always_comb begin
    base = table_base(tbl_sel);
    kind = K_PLAIN;
    tgt  = off;
    if (off >= OFS_REC0 && off <= OFS_REC_LAST) begin
      kind = K_REC;
      tgt  = rec_addr(base, obj_idx, off[REC_LOG-1:0]);
    end else if (off == OFS_FLD) begin
      kind = K_FLD;
      tgt  = field_addr(base, obj_idx);
    end else if (off == OFS_BASE) begin
      kind = K_BASE;
    end else if (off == OFS_IDX) begin
      kind = K_IDX;
    end
  end
endmodule

// File: rtl/oat_ctrl.sv
module oat_ctrl
  import oat_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  host_req,
  input  logic  host_we,
  input  kind_t kind,
  output logic  ready,
  output logic  accept,
  output logic  wb_cycle,
  output logic  init_rd_sel,
  output logic  init_rd_idx,
  output logic  init_ld_sel,
  output logic  init_ld_idx
);
  st_t st, st_nx;

  always_comb begin
    st_nx = st;
    case (st)
      S_LOAD_SEL:  st_nx = S_LOAD_IDX;
      S_LOAD_IDX:  st_nx = S_LOAD_DONE;
      S_LOAD_DONE: st_nx = S_IDLE;
      S_IDLE:      if (host_req && host_we && kind == K_FLD) st_nx = S_WBACK;
      S_WBACK:     st_nx = S_IDLE;
      default:     st_nx = S_LOAD_SEL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= S_LOAD_SEL;
    else        st <= st_nx;
  end

  assign ready       = (st == S_IDLE);
  assign accept      = ready && host_req;
  assign wb_cycle    = (st == S_WBACK);
  assign init_rd_sel = (st == S_LOAD_SEL);
  assign init_rd_idx = (st == S_LOAD_IDX);
  assign init_ld_sel = (st == S_LOAD_IDX);
  assign init_ld_idx = (st == S_LOAD_DONE);
endmodule

// File: rtl/oat_port.sv
module oat_port
  import oat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_req,
  input  logic             host_we,
  input  logic [WIN_W-1:0] host_addr,
  input  logic [DW-1:0]    host_wdata,
  output logic             host_ready,
  output logic [DW-1:0]    host_rdata,
  output logic             host_rvalid,
  output logic             ram_en,
  output logic             ram_we,
  output logic [WIN_W-1:0] ram_addr,
  output logic [DW-1:0]    ram_wdata,
  input  logic [DW-1:0]    ram_rdata
);
  kind_t              kind;
  logic [WIN_W-1:0]   tgt;
  logic               tbl_sel;
  logic [IDX_W-1:0]   obj_idx;
  logic [SHIFT_W-1:0] fld_shift;
  logic accept, wb_cycle, init_rd_sel, init_rd_idx, init_ld_sel, init_ld_idx;
  logic ld_sel, ld_idx, d_sel;
  logic [IDX_W-1:0]   d_idx;
  logic [WIN_W-1:0]   fld_addr_q;
  logic [FLD_W-1:0]   fld_val_q;
  logic               rvalid_q;
  logic               host_wr_acc;

  oat_decode u_dec (
    .off(host_addr), .tbl_sel(tbl_sel), .obj_idx(obj_idx), .kind(kind), .tgt(tgt)
  );

  oat_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we), .kind(kind),
    .ready(host_ready), .accept(accept), .wb_cycle(wb_cycle),
    .init_rd_sel(init_rd_sel), .init_rd_idx(init_rd_idx),
    .init_ld_sel(init_ld_sel), .init_ld_idx(init_ld_idx)
  );

  assign host_wr_acc = accept && host_we;
  assign ld_sel = init_ld_sel || (host_wr_acc && kind == K_BASE);
  assign ld_idx = init_ld_idx || (host_wr_acc && kind == K_IDX);
  assign d_sel  = (init_ld_sel || init_ld_idx) ? ram_rdata[0] : host_wdata[0];
  assign d_idx  = (init_ld_sel || init_ld_idx) ? ram_rdata[IDX_W-1:0] : host_wdata[IDX_W-1:0];

  oat_regs u_regs (
    .clk(clk), .rst_n(rst_n), .ld_sel(ld_sel), .ld_idx(ld_idx),
    .d_sel(d_sel), .d_idx(d_idx),
    .tbl_sel(tbl_sel), .obj_idx(obj_idx), .fld_shift(fld_shift)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fld_addr_q <= '0;
      fld_val_q  <= '0;
      rvalid_q   <= 1'b0;
    end else begin
      rvalid_q <= accept && !host_we;
      if (host_wr_acc && kind == K_FLD) begin
        fld_addr_q <= tgt;
        fld_val_q  <= host_wdata[FLD_W-1:0];
      end
    end
  end

  always_comb begin
    ram_en    = 1'b0;
    ram_we    = 1'b0;
    ram_addr  = tgt;
    ram_wdata = host_wdata;
    if (init_rd_sel) begin
      ram_en   = 1'b1;
      ram_addr = OFS_BASE;
    end else if (init_rd_idx) begin
      ram_en   = 1'b1;
      ram_addr = OFS_IDX;
    end else if (wb_cycle) begin
      ram_en    = 1'b1;
      ram_we    = 1'b1;
      ram_addr  = fld_addr_q;
      ram_wdata = merge_field(ram_rdata, fld_val_q, fld_shift);
    end else if (accept) begin
      ram_en = 1'b1;
      ram_we = host_we && (kind != K_FLD);
    end
  end

  assign host_rdata  = ram_rdata;
  assign host_rvalid = rvalid_q;
endmodule

// File: rtl/oat_port_chk.sv
module oat_port_chk
  import oat_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               host_req,
  input logic               host_we,
  input logic [WIN_W-1:0]   host_addr,
  input logic [DW-1:0]      host_wdata,
  input logic               host_ready,
  input logic               host_rvalid,
  input logic               ram_en,
  input logic               ram_we,
  input logic [WIN_W-1:0]   ram_addr,
  input logic [DW-1:0]      ram_wdata,
  input logic [DW-1:0]      ram_rdata,
  input logic [SHIFT_W-1:0] cur_shift,
  input logic               wb_cycle
);
  logic acc;
  assign acc = host_req && host_ready;

  a_r1_init_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_ready && !wb_cycle && ram_en) |-> (!ram_we && (ram_addr == OFS_BASE || ram_addr == OFS_IDX)));

  a_r2_plain_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (host_addr < OFS_REC0 || host_addr > OFS_IDX)) |-> (ram_en && ram_addr == host_addr && ram_we == host_we));

  a_r3_base_stored: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && host_we && host_addr == OFS_BASE) |-> (ram_we && ram_addr == OFS_BASE && ram_wdata == host_wdata));

  a_r7_stall_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && host_we && host_addr == OFS_FLD) |=> (!host_ready && ram_en && ram_we && wb_cycle));

  a_r7_other_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cycle |-> (((ram_wdata ^ ram_rdata) & ~(8'h03 << cur_shift)) == 8'h00));

  a_r9_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !host_we) |=> host_rvalid);

  a_r10_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ready && !host_req) |-> !ram_en);
endmodule

bind oat_port oat_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
  .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
  .host_rvalid(host_rvalid), .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
  .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .cur_shift(fld_shift), .wb_cycle(wb_cycle)
);

// File: tb/oat_port_tb.sv
`timescale 1ns/1ps
module oat_port_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_req = 1'b0, host_we = 1'b0;
  logic [12:0] host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic host_ready, host_rvalid, ram_en, ram_we;
  logic [7:0] host_rdata, ram_wdata;
  logic [7:0] ram_rdata = '0;
  logic [12:0] ram_addr;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] mem [int];

  always #2 clk = ~clk;

  oat_port u_dut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid), .ram_en(ram_en),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  function automatic logic [7:0] peek(input int a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) mem[int'(ram_addr)] = ram_wdata;
      else        ram_rdata <= peek(int'(ram_addr));
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic we, input logic [12:0] a, input logic [7:0] d,
                       output logic [7:0] rd, output logic rv, output logic rdy_after);
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d;
    while (!host_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    host_req = 1'b0;
    rd = host_rdata; rv = host_rvalid; rdy_after = host_ready;
  endtask

  // {we, addr, wdata, expected read}
  localparam int NV = 19;
  localparam logic [29:0] VEC [NV] = '{
    {1'b0, 13'h1FF0, 8'h00, 8'h11},
    {1'b0, 13'h1FF3, 8'h00, 8'h44},
    {1'b0, 13'h1FF4, 8'h00, 8'hFF},
    {1'b1, 13'h1FF4, 8'h00, 8'h00},
    {1'b0, 13'h1FF4, 8'h00, 8'hF3},
    {1'b1, 13'h1FF5, 8'h00, 8'h00},
    {1'b1, 13'h1FF1, 8'h5A, 8'h00},
    {1'b0, 13'h1FF1, 8'h00, 8'h5A},
    {1'b0, 13'h1FF5, 8'h00, 8'h00},
    {1'b1, 13'h1FF6, 8'h7F, 8'h00},
    {1'b1, 13'h1FF2, 8'hC3, 8'h00},
    {1'b0, 13'h1FF2, 8'h00, 8'hC3},
    {1'b1, 13'h1FF4, 8'h02, 8'h00},
    {1'b0, 13'h1FF4, 8'h00, 8'h80},
    {1'b0, 13'h1FF6, 8'h00, 8'h7F},
    {1'b1, 13'h0123, 8'h77, 8'h00},
    {1'b0, 13'h0123, 8'h00, 8'h77},
    {1'b1, 13'h1FF7, 8'h99, 8'h00},
    {1'b0, 13'h1FF7, 8'h00, 8'h99}
  };

  function automatic string req_of(input int i);
    case (i)
      0, 1, 6, 7, 10, 11: return "R5";
      2:                  return "R6";
      3, 4, 12, 13:       return "R7";
      5:                  return "R3";
      8, 14:              return "R8";
      9:                  return "R4";
      default:            return "R2";
    endcase
  endfunction

  task automatic reset_and_check();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 ready low in reset", {15'd0, host_ready}, 16'd0);
    check("R9 rvalid low in reset", {15'd0, host_rvalid}, 16'd0);
    rst_n = 1'b1;
    #0.5;
    check("R1 first init read", {2'b0, ram_en, ram_we, ram_addr}, {2'b0, 1'b1, 1'b0, 13'h1FF5});
    @(negedge clk);
    check("R1 second init read", {2'b0, ram_en, ram_we, ram_addr}, {2'b0, 1'b1, 1'b0, 13'h1FF6});
    @(negedge clk);
    check("R1 still not ready", {14'd0, host_ready, ram_en}, 16'd0);
    @(negedge clk);
    check("R1 ready after load", {15'd0, host_ready}, 16'd1);
  endtask

  initial begin
    logic [7:0] rd;
    logic rv, ra;
    mem[32'h1FF5] = 8'h01;  // base 0x1800
    mem[32'h1FF6] = 8'h05;  // index 5, shift 2
    mem[32'h1814] = 8'h11; mem[32'h1815] = 8'h22;
    mem[32'h1816] = 8'h33; mem[32'h1817] = 8'h44;
    mem[32'h1A01] = 8'hFF;
    reset_and_check();

    for (int i = 0; i < NV; i++) begin
      do_op(VEC[i][29], VEC[i][28:16], VEC[i][15:8], rd, rv, ra);
      if (!VEC[i][29]) begin
        check(req_of(i), {8'd0, rd}, {8'd0, VEC[i][7:0]});
        check("R9 rvalid after read", {15'd0, rv}, 16'd1);
      end else begin
        check("R9 rvalid low after write", {15'd0, rv}, 16'd0);
        if (VEC[i][28:16] == 13'h1FF4)
          check("R7 stalled during write-back", {15'd0, ra}, 16'd0);
        else
          check("R10 ready after plain write", {15'd0, ra}, 16'd1);
      end
    end

    check("R7 merged byte idx5", {8'd0, peek(32'h1A01)}, 16'h00F3);
    check("R5 record write base lo", {8'd0, peek(32'h1C15)}, 16'h005A);
    check("R5 record write idx127", {8'd0, peek(32'h1DFE)}, 16'h00C3);
    check("R7 merged byte idx127", {8'd0, peek(32'h1E1F)}, 16'h0080);
    check("R2 plain write", {8'd0, peek(32'h0123)}, 16'h0077);
    check("R3 base byte stored", {8'd0, peek(32'h1FF5)}, 16'h0000);
    check("R4 index byte stored", {8'd0, peek(32'h1FF6)}, 16'h007F);

    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R10 no RAM access when idle", {15'd0, ram_en}, 16'd0);
    end

    mem[32'h1DFF] = 8'hBE;  // base 0x1C00 + 4*127 + 3
    reset_and_check();
    do_op(1'b0, 13'h1FF3, 8'h00, rd, rv, ra);
    check("R1 settings reloaded from RAM", {8'd0, rd}, 16'h00BE);

    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule